// File: doc/BRIEF.md
# DS3 Far-End Alarm Code Receiver

This block sits behind a DS3 framer. It receives the serial far-end alarm and control bits that the framer has already pulled out of the C-bit overhead. It looks for 16-bit codewords in that stream and extracts the 6-bit message carried by each one. It keeps a sliding history of the most recent messages.

A message becomes the validated code when it repeats often enough in that history. The validated code is then latched into a register that software can read. It is withdrawn again when later codewords disagree with it too often.

Validation and withdrawal each set their own sticky status bit, and each bit has an enable. A single interrupt line tells the local processor that something needs attention. The processor reaches the code register and the control/status register through a byte-wide read/write port. The status bits clear themselves when the control/status register is read.

Top module: `feac_rx_processor`

## Requirements
- R1: A codeword is 16 serial bits, numbered by arrival: bit 0 is 0, bits 1..6 carry code bits 0..5 (code LSB first), bit 7 is 0, and bits 8..15 are all 1. The block searches one bit position at a time for this pattern. A codeword that breaks the pattern (for example with bit 15 = 0) is not recorded. At least 16 new bits are needed after reset, and after each recognised codeword, before the next one is accepted.
- R2: The code register is at address 0. It reads as {1'b0, code[5:0], 1'b0}, so bits 7 and 0 are always 0.
- R3: A code is validated when all of the following hold:
  - it appears at least 8 times among the last 10 codewords received since the previous validation;
  - either no code is currently valid, or it differs from the held code.
  On validation, the code is written to the code register, the valid status bit is set and the FEAC-valid flag becomes 1.
- R4: Further codewords equal to the held valid code cause no new validation event, and the valid status bit stays clear.
- R5: Removal happens when all of the following hold:
  - a code is valid;
  - at least 10 codewords have been received since the last validation;
  - 3 or more of the last 10 codewords differ from the held code.
  On removal, the remove status bit is set, the FEAC-valid flag is cleared to 0 and the code register is cleared to 0.
- R6: The control/status register is at address 1. Its layout is:
  - bit 4: FEAC-valid flag;
  - bit 3: remove interrupt enable;
  - bit 2: remove status;
  - bit 1: valid interrupt enable;
  - bit 0: valid status.
  Bits 7..5 read as 0.
- R7: Reading address 1 clears both status bits. If a read and a new event reach the register in the same cycle, the status bit stays set.
- R8: Only bits 3 and 1 of address 1 can be written. Writes to the other bits, and to address 0, have no effect.
- R9: `irq` = (valid status AND valid enable) OR (remove status AND remove enable).
- R10: Reset clears the code register, the history, both status bits, the valid flag and both enables. Both addresses then read 0 and `irq` is 0.
- R11: If a different code reaches 8 matches before a removal has been decided, it replaces the held code directly, and the remove status is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit_vld | input | 1 | Qualifies `rx_bit` for one cycle |
| rx_bit | input | 1 | Serial alarm/control channel bit |
| cpu_addr | input | 1 | Register select: 0 = code register, 1 = control/status register |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe; `cpu_rdata` is updated on the next clock edge |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench starts a stream with junk bits before the first codeword and inserts a malformed codeword. A framer that required fixed alignment, or one that ignored the trailing ones, would then count the wrong number of codes.

It sends exactly seven and then eight matching codes, and two and then three differing codes. A window threshold that is off by one would validate or remove one codeword early or late.

It makes a new code take over without any disagreement being counted, to show validation has priority over removal. It also lands a status read in the same cycle as a validation event; a design that let the read win would lose the event.

Finally it masks both enables during a removal. A wrong `irq` gate would raise the interrupt anyway.

// File: rtl/feac_rx_pkg.sv
package feac_rx_pkg;
  localparam int CODE_BITS   = 6;
  localparam int FLAG_ONES   = 8;
  localparam int HIST_DEPTH  = 10;
  localparam int VALID_MIN   = 8;
  localparam int REMOVE_MIN  = 3;
  localparam int REG_BYTE    = 8;
  localparam logic ADDR_CODE = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/feac_word_framer.sv
module feac_word_framer #(
  parameter int CODE_W = feac_rx_pkg::CODE_BITS,
  parameter int ONES_W = feac_rx_pkg::FLAG_ONES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              code_stb,
  output logic [CODE_W-1:0] code
);
  localparam int WORD_W = CODE_W + 2 + ONES_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sr, sr_nxt;
  logic [CNT_W-1:0]  seen;
  logic              hit;

  // newest bit enters at the top; bit 0 is the oldest of the window
  assign sr_nxt = {bit_in, sr[WORD_W-1:1]};

  always_comb begin
    hit = bit_vld
       && (seen >= CNT_W'(WORD_W - 1))
       && !sr_nxt[0]
       && !sr_nxt[CODE_W+1]
       && (&sr_nxt[WORD_W-1:CODE_W+2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      seen     <= '0;
      code_stb <= 1'b0;
      code     <= '0;
    end else begin
      code_stb <= 1'b0;
      if (bit_vld) begin
        sr <= sr_nxt;
        if (hit) begin
          seen     <= '0;
          code_stb <= 1'b1;
          code     <= sr_nxt[CODE_W:1];
        end else if (seen != CNT_W'(WORD_W)) begin
          seen <= seen + 1'b1;
        end
      end
    end
  end

  // R1: two recognised codewords need a full word of bits between them
  assert_stb_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    code_stb |=> !code_stb);
endmodule

// File: rtl/feac_code_history.sv
module feac_code_history #(
  parameter int CODE_W = feac_rx_pkg::CODE_BITS,
  parameter int DEPTH  = feac_rx_pkg::HIST_DEPTH,
  parameter int VAL_MIN = feac_rx_pkg::VALID_MIN,
  parameter int REM_MIN = feac_rx_pkg::REMOVE_MIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              code_stb,
  input  logic [CODE_W-1:0] code,
  input  logic              held_vld,
  input  logic [CODE_W-1:0] held_code,
  output logic              val_evt,
  output logic              rem_evt,
  output logic [CODE_W-1:0] evt_code
);
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [CODE_W-1:0] hist    [DEPTH];
  logic [CODE_W-1:0] win_nxt [DEPTH];
  logic [FILL_W-1:0] fill, fill_nxt, match_cnt, diff_cnt;
  logic              do_val, do_rem;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_win
      if (g == 0) begin : g_head
        assign win_nxt[g] = code;
      end else begin : g_tail
        assign win_nxt[g] = hist[g-1];
      end
    end
  endgenerate

  assign fill_nxt = (fill == FILL_W'(DEPTH)) ? fill : fill + 1'b1;

  always_comb begin
    match_cnt = '0;
    diff_cnt  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (FILL_W'(i) < fill_nxt) begin
        if (win_nxt[i] == code)      match_cnt = match_cnt + 1'b1;
        if (win_nxt[i] != held_code) diff_cnt  = diff_cnt + 1'b1;
      end
    end
    do_val = code_stb && (match_cnt >= FILL_W'(VAL_MIN))
          && (!held_vld || (code != held_code));
    do_rem = code_stb && !do_val && held_vld
          && (fill_nxt == FILL_W'(DEPTH)) && (diff_cnt >= FILL_W'(REM_MIN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      fill     <= '0;
      val_evt  <= 1'b0;
      rem_evt  <= 1'b0;
      evt_code <= '0;
    end else begin
      val_evt <= do_val;
      rem_evt <= do_rem;
      if (code_stb) begin
        for (int i = 0; i < DEPTH; i++) hist[i] <= win_nxt[i];
        fill     <= do_val ? '0 : fill_nxt;
        evt_code <= code;
      end
    end
  end

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (rst)
    fill <= FILL_W'(DEPTH));
  // R11: a validation wins over a removal in the same decision
  assert_evt_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(val_evt && rem_evt));
endmodule

// File: rtl/feac_reg_file.sv
module feac_reg_file #(
  parameter int CODE_W = feac_rx_pkg::CODE_BITS,
  parameter int DATA_W = feac_rx_pkg::REG_BYTE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              val_evt,
  input  logic              rem_evt,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq,
  output logic              held_vld,
  output logic [CODE_W-1:0] held_code
);
  import feac_rx_pkg::*;
  localparam int PAD_HI = DATA_W - CODE_W - 1;

  logic st_val, st_rem, en_val, en_rem;
  logic st_val_nxt, st_rem_nxt, en_val_nxt, en_rem_nxt;
  logic rd_ctl, wr_ctl;
  logic [DATA_W-1:0] ctl_view, code_view;

  assign rd_ctl = cpu_rd && (cpu_addr == ADDR_CTRL);
  assign wr_ctl = cpu_wr && (cpu_addr == ADDR_CTRL);

  always_comb begin
    st_val_nxt = val_evt || (st_val && !rd_ctl);
    st_rem_nxt = rem_evt || (st_rem && !rd_ctl);
    en_val_nxt = wr_ctl ? cpu_wdata[1] : en_val;
    en_rem_nxt = wr_ctl ? cpu_wdata[3] : en_rem;
    ctl_view   = '0;
    ctl_view[4:0] = {held_vld, en_rem, st_rem, en_val, st_val};
    code_view  = {{PAD_HI{1'b0}}, held_code, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_val    <= 1'b0;
      st_rem    <= 1'b0;
      en_val    <= 1'b0;
      en_rem    <= 1'b0;
      held_vld  <= 1'b0;
      held_code <= '0;
      cpu_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      st_val <= st_val_nxt;
      st_rem <= st_rem_nxt;
      en_val <= en_val_nxt;
      en_rem <= en_rem_nxt;
      irq    <= (st_val_nxt && en_val_nxt) || (st_rem_nxt && en_rem_nxt);
      if (val_evt) begin
        held_vld  <= 1'b1;
        held_code <= evt_code;
      end else if (rem_evt) begin
        held_vld  <= 1'b0;
        held_code <= '0;
      end
      if (cpu_rd) cpu_rdata <= rd_ctl ? ctl_view : code_view;
    end
  end

  assert_valid_sets_R3: assert property (@(posedge clk) disable iff (rst)
    val_evt |=> (held_vld && st_val && (held_code == $past(evt_code))));
  assert_remove_clears_R5: assert property (@(posedge clk) disable iff (rst)
    rem_evt |=> (!held_vld && st_rem));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_ctl && !val_evt && !rem_evt) |=> (!st_val && !st_rem));
  assert_code_pad_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && (cpu_addr == ADDR_CODE)) |=> (!cpu_rdata[0] && !cpu_rdata[DATA_W-1]));
endmodule

// File: rtl/feac_rx_processor.sv
module feac_rx_processor #(
  parameter int CODE_W  = feac_rx_pkg::CODE_BITS,
  parameter int ONES_W  = feac_rx_pkg::FLAG_ONES,
  parameter int DEPTH   = feac_rx_pkg::HIST_DEPTH,
  parameter int VAL_MIN = feac_rx_pkg::VALID_MIN,
  parameter int REM_MIN = feac_rx_pkg::REMOVE_MIN,
  parameter int DATA_W  = feac_rx_pkg::REG_BYTE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit_vld,
  input  logic              rx_bit,
  input  logic              cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq
);
  logic              code_stb, val_evt, rem_evt, held_vld;
  logic [CODE_W-1:0] code, evt_code, held_code;

  feac_word_framer #(.CODE_W(CODE_W), .ONES_W(ONES_W)) u_framer (
    .clk(clk), .rst(rst), .bit_vld(rx_bit_vld), .bit_in(rx_bit),
    .code_stb(code_stb), .code(code));

  feac_code_history #(.CODE_W(CODE_W), .DEPTH(DEPTH),
                      .VAL_MIN(VAL_MIN), .REM_MIN(REM_MIN)) u_hist (
    .clk(clk), .rst(rst), .code_stb(code_stb), .code(code),
    .held_vld(held_vld), .held_code(held_code),
    .val_evt(val_evt), .rem_evt(rem_evt), .evt_code(evt_code));

  feac_reg_file #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .val_evt(val_evt), .rem_evt(rem_evt),
    .evt_code(evt_code), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .irq(irq), .held_vld(held_vld), .held_code(held_code));
endmodule

// File: tb/tb_feac_rx_processor.sv
module tb_feac_rx_processor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit_vld = 1'b0, rx_bit = 1'b0;
  logic       cpu_addr = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [5:0] CA = 6'h2D, CB = 6'h13, CC = 6'h3A, CD = 6'h05, CE = 6'h21;

  always #5 clk = ~clk;

  feac_rx_processor dut (.clk(clk), .rst(rst), .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rx_bit_vld = 1'b1; rx_bit = b;
    @(negedge clk);
    rx_bit_vld = 1'b0;
  endtask

  task automatic send_raw(input logic [5:0] c, input bit good);
    logic [15:0] w;
    w = {8'hFF, 1'b0, c, 1'b0};
    if (!good) w[15] = 1'b0;
    for (int i = 0; i < 16; i++) begin
      rx_bit_vld = 1'b1; rx_bit = w[i];
      @(negedge clk);
    end
    rx_bit_vld = 1'b0;
  endtask

  task automatic send_n(input logic [5:0] c, input int n);
    for (int k = 0; k < n; k++) send_raw(c, 1'b1);
    settle(3);
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(1'b0, d); check("R10 code after reset", d, 8'h00);
    rd_reg(1'b1, d); check("R10 ctrl after reset", d, 8'h00);
    check("R10 irq after reset", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_enables;
    logic [7:0] d;
    wr_reg(1'b1, 8'hFF);
    wr_reg(1'b0, 8'hFF);
    rd_reg(1'b1, d); check("R8 only enables writable", d, 8'h0A);
    rd_reg(1'b0, d); check("R8 code reg not writable", d, 8'h00);
  endtask

  task automatic t_validate;
    logic [7:0] d;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_n(CA, 7);
    rd_reg(1'b1, d); check("R3 seven matches not enough", d, 8'h0A);
    send_raw(CA, 1'b0); settle(3);
    rd_reg(1'b1, d); check("R1 malformed word ignored", d, 8'h0A);
    send_n(CA, 1);
    check("R9 irq on valid", {7'b0, irq}, 8'h01);
    rd_reg(1'b1, d); check("R3 R6 valid status and flag", d, 8'h1B);
    rd_reg(1'b0, d); check("R2 code layout", d, {1'b0, CA, 1'b0});
    check("R7 irq drops after read", {7'b0, irq}, 8'h00);
    rd_reg(1'b1, d); check("R7 status cleared by read", d, 8'h1A);
  endtask

  task automatic t_repeat;
    logic [7:0] d;
    send_n(CA, 10);
    rd_reg(1'b1, d); check("R4 held code repeats no event", d, 8'h1A);
  endtask

  task automatic t_remove;
    logic [7:0] d;
    send_n(CB, 2);
    rd_reg(1'b1, d); check("R5 two differing not enough", d, 8'h1A);
    send_n(CB, 1);
    check("R9 irq on remove", {7'b0, irq}, 8'h01);
    rd_reg(1'b1, d); check("R5 remove status flag cleared", d, 8'h0E);
    rd_reg(1'b0, d); check("R5 code cleared", d, 8'h00);
    send_n(CB, 4);
    rd_reg(1'b1, d); check("R3 seven B not yet", d, 8'h0A);
    send_n(CB, 1);
    rd_reg(1'b1, d); check("R3 revalidate after removal", d, 8'h1B);
    rd_reg(1'b0, d); check("R3 code B", d, {1'b0, CB, 1'b0});
  endtask

  task automatic t_priority;
    logic [7:0] d;
    send_n(CC, 8);
    rd_reg(1'b1, d); check("R11 direct replace no remove", d, 8'h1B);
    rd_reg(1'b0, d); check("R11 code C", d, {1'b0, CC, 1'b0});
  endtask

  task automatic t_collision;
    logic [7:0] d;
    send_n(CD, 7);
    send_raw(CD, 1'b1);
    @(negedge clk);
    cpu_addr = 1'b1; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    check("R7 collision read sees old", cpu_rdata, 8'h1A);
    settle(2);
    rd_reg(1'b1, d); check("R7 event survives same-cycle read", d, 8'h1B);
  endtask

  task automatic t_masked;
    logic [7:0] d;
    wr_reg(1'b1, 8'h00);
    send_n(CE, 3);
    send_n(CD, 7);
    check("R9 masked irq stays low", {7'b0, irq}, 8'h00);
    rd_reg(1'b1, d); check("R5 R9 remove status masked", d, 8'h04);
    rd_reg(1'b0, d); check("R5 code cleared again", d, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst = 1'b0;
    settle(2);
    t_reset();
    t_enables();
    t_validate();
    t_repeat();
    t_remove();
    t_priority();
    t_collision();
    t_masked();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule